// File: doc/BRIEF.md
# Work-Steal Table Arbiter

This block sits at the centre of a cluster of processors and tells an idle processor where to steal work from. It holds a table with one slot for each processor. A slot is either empty or names a donor processor. It also keeps a registered copy of one load bit per processor. Each processor raises its own load bit while its pending queue holds more than its lower limit.

An idle processor never searches the cluster. It raises its request line and receives the content of its own slot in one atomic step, and that slot becomes empty in the same step. Requests from several processors are served one per cycle. A background engine walks the slots, one slot per cycle. When it finds an empty slot, it writes in a loaded processor other than the slot's owner. It picks donors in rotating order so that demand is spread across them. When a processor is told that no donor was available, the arbiter holds back that processor's next request for a fixed retry interval.

Top module: `wst_steal_arbiter`

## Requirements
- R1: After reset every slot is empty, `ack_o` is zero and `resp_valid_o` is low. A request issued while no load bit has ever been set returns empty.
- R2: A granted request returns the requester's slot and leaves that slot empty in the same clock edge. `resp_valid_o` high means a donor; `resp_id_o` then carries the donor number, zero-extended to 6 bits. `resp_valid_o` low means empty, and `resp_id_o` is then zero.
- R3: At most one bit of `ack_o` is high in any cycle. The bit for processor p is a one-cycle pulse one cycle after the edge that accepted `req_i[p]`. A requester must drop its request in the cycle its ack is high, and a request seen during its own ack cycle is ignored.
- R4: Pending requests are served round-robin. When all processors request together, consecutive grants go to processor numbers that each step up by one, modulo NUM_PROC.
- R5: `load_i` is registered into the load table. The refill engine visits slot k at the k-th clock edge after reset release, counted from 0 and taken modulo NUM_PROC. If that slot is empty and some other processor's registered load bit is set, the engine writes that processor into the slot.
- R6: The refill engine never names a processor as its own donor. While a processor's slot is empty and it is the only loaded processor, that slot stays empty.
- R7: Donors are chosen round-robin. The search starts after the donor that was last written. With two loaded processors and every slot empty, each of the two is written into at least two of the other slots.
- R8: When a grant and a refill target the same slot at the same edge, the grant wins. The refill write is dropped, and the slot stays empty until the engine's next visit.
- R9: After an empty response to processor p, requests from p are not granted for RETRY_CYC edges. A request held high is granted exactly RETRY_CYC+1 edges after the failing grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | NUM_PROC | Load bit of each processor, set while its pending queue is above its lower limit |
| req_i | input | NUM_PROC | Steal request of each processor, held until acked |
| ack_o | output | NUM_PROC | One-hot, one-cycle acknowledge to the served processor |
| resp_valid_o | output | 1 | Returned slot named a donor |
| resp_id_o | output | 6 | Donor processor number, zero when the slot was empty |

## Verification
A single requester is tried against a filled slot and then against the slot it has just emptied. This tells a true read-and-clear apart from a plain read. The only loaded processor also asks for its own slot, which would expose a self-assignment. All processors request at once to show one grant per cycle and a rotation step of one. A request held after a failure measures the exact retry gap. A request is timed onto the edge where the refill engine visits that same slot, which separates request priority from refill priority. With two loaded processors and all slots drained, the donors handed out reveal whether donor choice rotates or always falls on the same processor.

// File: rtl/wst_pkg.sv
package wst_pkg;
  localparam int unsigned ID_W = 6;  // supports up to 64 processors
  typedef logic [ID_W-1:0] proc_id_t;
  typedef struct packed {
    logic     vld;
    proc_id_t id;
  } slot_t;
endpackage

// File: rtl/wst_rr_arb.sv
module wst_rr_arb #(
  parameter int unsigned NUM_PROC = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PROC-1:0]   req_i,
  output logic                  gnt_vld_o,
  output wst_pkg::proc_id_t     gnt_idx_o
);
  import wst_pkg::*;

  proc_id_t            ptr_q;
  logic [NUM_PROC-1:0] rot;
  int                  off;
  int                  sum;

  always_comb begin
    rot       = (req_i >> ptr_q) | (req_i << (NUM_PROC - int'(ptr_q)));
    gnt_vld_o = 1'b0;
    off       = 0;
    for (int k = 0; k < NUM_PROC; k++) begin
      if (!gnt_vld_o && rot[k]) begin
        gnt_vld_o = 1'b1;
        off       = k;
      end
    end
    sum = int'(ptr_q) + off;
    if (sum >= NUM_PROC) sum = sum - NUM_PROC;
    gnt_idx_o = proc_id_t'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (gnt_vld_o) begin
      ptr_q <= (int'(gnt_idx_o) == NUM_PROC - 1) ? '0 : gnt_idx_o + proc_id_t'(1);
    end
  end
endmodule

// File: rtl/wst_refill.sv
module wst_refill #(
  parameter int unsigned NUM_PROC = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PROC-1:0]   load_i,
  input  logic [NUM_PROC-1:0]   slot_vld_i,
  input  logic                  hold_vld_i,
  input  wst_pkg::proc_id_t     hold_idx_i,
  output logic                  wr_en_o,
  output wst_pkg::proc_id_t     wr_idx_o,
  output wst_pkg::proc_id_t     wr_id_o
);
  import wst_pkg::*;

  proc_id_t            scan_q;
  proc_id_t            last_q;
  logic [NUM_PROC-1:0] self_m;
  logic [NUM_PROC-1:0] cand;
  logic [NUM_PROC-1:0] rot;
  logic                cur_vld;
  logic                found;
  int                  start;
  int                  off;
  int                  sum;

  always_comb begin
    cur_vld = 1'b0;
    for (int i = 0; i < NUM_PROC; i++) begin
      self_m[i] = (proc_id_t'(i) == scan_q);
      if (self_m[i]) cur_vld = slot_vld_i[i];
    end
    cand  = load_i & ~self_m;
    start = int'(last_q) + 1;
    if (start >= NUM_PROC) start = 0;
    rot   = (cand >> start) | (cand << (NUM_PROC - start));
    found = 1'b0;
    off   = 0;
    for (int k = 0; k < NUM_PROC; k++) begin
      if (!found && rot[k]) begin
        found = 1'b1;
        off   = k;
      end
    end
    sum = start + off;
    if (sum >= NUM_PROC) sum = sum - NUM_PROC;
    wr_id_o  = proc_id_t'(sum);
    wr_idx_o = scan_q;
    // a grant on the scanned slot takes priority over the refill write
    wr_en_o  = found && !cur_vld && !(hold_vld_i && hold_idx_i == scan_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q <= '0;
      last_q <= proc_id_t'(NUM_PROC - 1);
    end else begin
      scan_q <= (int'(scan_q) == NUM_PROC - 1) ? '0 : scan_q + proc_id_t'(1);
      if (wr_en_o) last_q <= wr_id_o;
    end
  end
endmodule

// File: rtl/wst_backoff.sv
module wst_backoff #(
  parameter int unsigned NUM_PROC  = 8,
  parameter int unsigned RETRY_CYC = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fail_vld_i,
  input  wst_pkg::proc_id_t     fail_idx_i,
  output logic [NUM_PROC-1:0]   blocked_o
);
  import wst_pkg::*;

  localparam int unsigned CNT_W = $clog2(RETRY_CYC + 1);

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_proc
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (fail_vld_i && fail_idx_i == proc_id_t'(g)) begin
        cnt_q <= CNT_W'(RETRY_CYC);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end

    assign blocked_o[g] = (cnt_q != '0);
  end
endmodule

// File: rtl/wst_steal_arbiter.sv
module wst_steal_arbiter #(
  parameter int unsigned NUM_PROC  = 8,
  parameter int unsigned RETRY_CYC = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_PROC-1:0]        load_i,
  input  logic [NUM_PROC-1:0]        req_i,
  output logic [NUM_PROC-1:0]        ack_o,
  output logic                       resp_valid_o,
  output logic [wst_pkg::ID_W-1:0]   resp_id_o
);
  import wst_pkg::*;

  slot_t               slot_q [NUM_PROC];
  logic [NUM_PROC-1:0] slot_vld;
  logic [NUM_PROC-1:0] load_q;
  logic [NUM_PROC-1:0] ack_q;
  logic [NUM_PROC-1:0] blocked;
  logic [NUM_PROC-1:0] elig;
  slot_t               resp_q;
  slot_t               gnt_slot;
  logic                gnt_vld;
  proc_id_t            gnt_idx;
  logic                wr_en;
  proc_id_t            wr_idx;
  proc_id_t            wr_id;
  logic                fail_vld;

  assign elig = req_i & ~ack_q & ~blocked;

  wst_rr_arb #(.NUM_PROC(NUM_PROC)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (elig),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx)
  );

  wst_refill #(.NUM_PROC(NUM_PROC)) u_refill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_q),
    .slot_vld_i (slot_vld),
    .hold_vld_i (gnt_vld),
    .hold_idx_i (gnt_idx),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_id_o    (wr_id)
  );

  wst_backoff #(.NUM_PROC(NUM_PROC), .RETRY_CYC(RETRY_CYC)) u_backoff (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fail_vld_i (fail_vld),
    .fail_idx_i (gnt_idx),
    .blocked_o  (blocked)
  );

  always_comb begin
    gnt_slot = '0;
    for (int i = 0; i < NUM_PROC; i++) begin
      slot_vld[i] = slot_q[i].vld;
      if (gnt_vld && gnt_idx == proc_id_t'(i)) gnt_slot = slot_q[i];
    end
    fail_vld = gnt_vld && !gnt_slot.vld;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PROC; i++) slot_q[i] <= '0;
      load_q <= '0;
      ack_q  <= '0;
      resp_q <= '0;
    end else begin
      load_q <= load_i;
      resp_q <= gnt_slot;
      for (int i = 0; i < NUM_PROC; i++) begin
        ack_q[i] <= gnt_vld && gnt_idx == proc_id_t'(i);
        if (gnt_vld && gnt_idx == proc_id_t'(i)) begin
          slot_q[i] <= '0;
        end else if (wr_en && wr_idx == proc_id_t'(i)) begin
          slot_q[i] <= '{vld: 1'b1, id: wr_id};
        end
      end
    end
  end

  assign ack_o        = ack_q;
  assign resp_valid_o = resp_q.vld;
  assign resp_id_o    = resp_q.id;
endmodule

// File: rtl/wst_steal_arbiter_chk.sv
module wst_steal_arbiter_chk #(
  parameter int unsigned NUM_PROC  = 8,
  parameter int unsigned RETRY_CYC = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_PROC-1:0]      req_i,
  input logic [NUM_PROC-1:0]      ack_o,
  input logic                     resp_valid_o,
  input logic [wst_pkg::ID_W-1:0] resp_id_o,
  input logic [NUM_PROC-1:0]      slot_vld,
  input logic [NUM_PROC-1:0]      load_q,
  input logic                     wr_en,
  input wst_pkg::proc_id_t        wr_idx,
  input wst_pkg::proc_id_t        wr_id
);
  import wst_pkg::*;

  localparam int unsigned CNT_W = $clog2(RETRY_CYC + 1);

  assert_one_ack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  assert_ack_after_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o & ~$past(req_i)) == '0);

  assert_empty_id_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0 && !resp_valid_o) |-> resp_id_o == '0);

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_chk
    logic [CNT_W-1:0] bo_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bo_q <= '0;
      else if (ack_o[g] && !resp_valid_o) bo_q <= CNT_W'(RETRY_CYC);
      else if (bo_q != '0) bo_q <= bo_q - CNT_W'(1);
    end

    assert_retry_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o[g] |-> bo_q == '0);

    // R2 and R8: a served slot is empty right after the grant, even with a refill visit
    assert_served_slot_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o[g] |-> !slot_vld[g]);

    assert_no_self_resp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_o[g] && resp_valid_o) |-> resp_id_o != proc_id_t'(g));

    assert_refill_loaded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en && wr_id == proc_id_t'(g)) |-> (load_q[g] && wr_idx != proc_id_t'(g)));
  end
endmodule

bind wst_steal_arbiter wst_steal_arbiter_chk #(
  .NUM_PROC (NUM_PROC),
  .RETRY_CYC(RETRY_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ack_o       (ack_o),
  .resp_valid_o(resp_valid_o),
  .resp_id_o   (resp_id_o),
  .slot_vld    (slot_vld),
  .load_q      (load_q),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_id       (wr_id)
);

// File: tb/wst_steal_arbiter_tb.sv
module wst_steal_arbiter_tb;
  localparam int NP    = 8;
  localparam int RETRY = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] load_i = '0;
  logic [NP-1:0] req_i = '0;
  logic [NP-1:0] ack_o;
  logic          resp_valid_o;
  logic [5:0]    resp_id_o;

  int n_tests = 0;
  int n_fail  = 0;
  int edge_n  = 0;

  typedef struct {
    int    proc;
    bit    any;
    bit    vld;
    int    id;
    bit    chk_id;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  bit log_en = 1'b0;
  int order_log[$];
  int got_id[NP];

  wst_steal_arbiter #(.NUM_PROC(NP), .RETRY_CYC(RETRY)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .req_i(req_i),
    .ack_o(ack_o), .resp_valid_o(resp_valid_o), .resp_id_o(resp_id_o)
  );

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) edge_n <= 0;
    else         edge_n <= edge_n + 1;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops the matching scoreboard entry for each ack
  always @(negedge clk) begin
    if (rst_ni && ack_o != '0) begin
      int p;
      int hit;
      p = -1;
      hit = -1;
      chk($countones(ack_o) == 1, "R3", "acks in one cycle", $countones(ack_o), 1);
      for (int i = 0; i < NP; i++) if (ack_o[i]) p = i;
      for (int i = 0; i < sb_q.size(); i++) if (hit < 0 && sb_q[i].proc == p) hit = i;
      if (hit < 0) begin
        chk(1'b0, "R3", "unexpected ack for proc", p, -1);
      end else begin
        exp_t e;
        e = sb_q[hit];
        sb_q.delete(hit);
        if (!e.any) chk(resp_valid_o == e.vld, e.tag, "resp_valid", resp_valid_o, e.vld);
        if (e.chk_id) chk(int'(resp_id_o) == e.id, e.tag, "resp_id", resp_id_o, e.id);
        if (!resp_valid_o) chk(resp_id_o == 0, "R2", "id of empty slot", resp_id_o, 0);
      end
      if (log_en) begin
        order_log.push_back(p);
        got_id[p] = resp_valid_o ? int'(resp_id_o) : -1;
      end
    end
  end

  // driver: call at a negedge, returns at a negedge
  task automatic steal(int p, bit any, bit ev, int eid, bit cid, string tag);
    sb_q.push_back('{p, any, ev, eid, cid, tag});
    req_i[p] = 1'b1;
    do @(negedge clk); while (!ack_o[p]);
    req_i[p] = 1'b0;
    @(negedge clk);
    chk(!ack_o[p], "R3", "ack longer than one cycle", ack_o[p], 0);
  endtask

  task automatic all_steal(bit any, bit ev);
    for (int i = 0; i < NP; i++) begin
      automatic int p = i;
      fork steal(p, any, ev, 0, 1'b0, "R4"); join_none
    end
    wait fork;
  endtask

  task automatic wait_phase(int r);
    do @(negedge clk); while ((edge_n % NP) != r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ack_o == '0, "R1", "ack in reset", ack_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ack_o == '0 && !resp_valid_o, "R1", "outputs after reset", {ack_o, resp_valid_o}, 0);
    steal(1, 0, 0, 0, 1, "R1");
    repeat (NP) @(negedge clk);

    // single loaded donor: fill, then read-and-clear
    load_i = 8'b0000_1000;
    repeat (3 * NP) @(negedge clk);
    load_i = '0;
    repeat (2) @(negedge clk);
    steal(0, 0, 1, 3, 1, "R2");
    steal(0, 0, 0, 0, 1, "R2");
    steal(3, 0, 0, 0, 1, "R6");
    steal(6, 0, 1, 3, 1, "R5");
    repeat (10) @(negedge clk);

    // all request at once: round-robin order, also drains every slot
    order_log.delete();
    log_en = 1'b1;
    all_steal(1'b1, 1'b0);
    log_en = 1'b0;
    chk(order_log.size() == NP, "R4", "grants served", order_log.size(), NP);
    for (int k = 0; k + 1 < order_log.size(); k++)
      chk(order_log[k+1] == (order_log[k] + 1) % NP, "R4", "next granted proc",
          order_log[k+1], (order_log[k] + 1) % NP);
    repeat (10) @(negedge clk);

    // held request after a failure: exact retry gap
    begin
      int t1;
      int t2;
      sb_q.push_back('{4, 1'b0, 1'b0, 0, 1'b1, "R9"});
      sb_q.push_back('{4, 1'b0, 1'b0, 0, 1'b1, "R9"});
      req_i[4] = 1'b1;
      do @(negedge clk); while (!ack_o[4]);
      t1 = edge_n;
      do @(negedge clk); while (!ack_o[4]);
      t2 = edge_n;
      req_i[4] = 1'b0;
      chk(t2 - t1 == RETRY + 1, "R9", "edges between grants", t2 - t1, RETRY + 1);
    end
    repeat (2 * NP) @(negedge clk);

    // grant and refill hit slot 0 at the same edge
    wait_phase(1);
    load_i = 8'b0000_1000;
    wait_phase(0);
    steal(0, 0, 0, 0, 1, "R8");
    steal(0, 0, 0, 0, 1, "R8");
    repeat (3 * NP) @(negedge clk);
    steal(0, 0, 1, 3, 1, "R5");

    // two loaded donors: drain, refill, read all
    load_i = '0;
    repeat (10) @(negedge clk);
    all_steal(1'b1, 1'b0);
    repeat (10) @(negedge clk);
    load_i = 8'b0010_0100;
    repeat (3 * NP) @(negedge clk);
    load_i = '0;
    for (int i = 0; i < NP; i++) got_id[i] = -1;
    log_en = 1'b1;
    for (int i = 0; i < NP; i++) begin
      automatic int p = i;
      fork
        if (p == 2)      steal(p, 0, 1, 5, 1, "R6");
        else if (p == 5) steal(p, 0, 1, 2, 1, "R6");
        else             steal(p, 0, 1, 0, 0, "R7");
      join_none
    end
    wait fork;
    log_en = 1'b0;
    begin
      int c2;
      int c5;
      c2 = 0;
      c5 = 0;
      for (int i = 0; i < NP; i++) if (i != 2 && i != 5) begin
        if (got_id[i] == 2) c2++;
        if (got_id[i] == 5) c5++;
      end
      chk(c2 >= 2, "R7", "slots given donor 2", c2, 2);
      chk(c5 >= 2, "R7", "slots given donor 5", c5, 2);
      chk(c2 + c5 == NP - 2, "R7", "slots given a donor", c2 + c5, NP - 2);
    end
    chk(sb_q.size() == 0, "R3", "unserved requests", sb_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule